// File: doc/BRIEF.md
# Configuration Image Header Parser

This block sits between a byte source holding a programmable-logic configuration image and the port that loads that image into the device. It takes bytes one at a time on a valid/ready input, checks and drops the image header, and passes on only the configuration payload that follows it. The header is a fixed 13-byte signature, then a run of tagged information records whose contents are skipped, then a terminating record that must carry the tag 0x65 and gives the payload size as a 32-bit big-endian count.

Exactly that many payload bytes are forwarded, unchanged and in order, on a valid/ready output whose final byte carries a last marker. When the final byte has been taken the block raises a sticky done flag. Any header fault instead raises a sticky error flag with a code, stops input, and forwards nothing. A synchronous reset is the only way to start a new image.

Top module: `cfg_hdr_strip`

## Requirements
- R1: The first 13 input bytes must be 00 09 0F F0 0F F0 0F F0 0F F0 00 00 01 (in this order); the first byte that differs raises err with err_code 1 on the cycle after it is accepted.
- R2: After the signature come four records, each a tag byte of any value, a 2-byte big-endian length (high byte first) and that many content bytes; tags and contents are consumed and never appear on the output.
- R3: A record length of 256 or more raises err with err_code 2 on the cycle after its second length byte is accepted; a length of 255 is accepted.
- R4: The byte after the fourth record must be 0x65; any other value raises err with err_code 3 on the cycle after it is accepted.
- R5: The four bytes after the 0x65 tag form a big-endian payload count N; the next N input bytes appear on the output unchanged and in order, and no input byte beyond them is accepted.
- R6: out_last is high together with out_valid for the N-th payload byte and for no other output byte.
- R7: done rises on the cycle after the N-th payload byte is accepted on the output, or, when N is zero, on the cycle after the fourth count byte is accepted with no output byte; done then stays high and err stays low until reset.
- R8: Once err is high it stays high with an unchanged err_code, in_ready stays low and out_valid stays low until reset; a failing image forwards no byte.
- R9: in_ready is high, so header bytes go at one per cycle, except while an output byte is held with out_ready low, after the N-th payload byte is taken, and after an error.
- R10: While out_valid is high and out_ready is low, out_valid, out_data and out_last hold their values.
- R11: After reset, in_ready is 1 and out_valid, done, err and err_code are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Image byte |
| in_valid | input | 1 | in_data holds a byte |
| in_ready | output | 1 | Block accepts in_data this cycle |
| out_data | output | 8 | Payload byte |
| out_valid | output | 1 | out_data holds a payload byte |
| out_last | output | 1 | Final payload byte |
| out_ready | input | 1 | Downstream takes out_data this cycle |
| done | output | 1 | Payload fully delivered (sticky) |
| err | output | 1 | Header fault (sticky) |
| err_code | output | 2 | 0 none, 1 signature, 2 record too long, 3 wrong tag |

## Verification
The properties assume that the downstream side only ever lowers out_ready as a stall and that the upstream side keeps a byte on in_data for as long as in_valid is high and in_ready is low; they also assume reset is held for at least one edge before each image. The bench keeps within that by changing in_data only after a byte has been taken, inserting random input bubbles and random output stalls, and pulsing reset for two edges before every image, so error, zero-length and back-pressure cases all start from the reset state.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

  localparam int SIG_LEN = 13;

  typedef enum logic [3:0] {
    ST_SIG,
    ST_FKEY,
    ST_FLEN,
    ST_FBODY,
    ST_EKEY,
    ST_PLEN,
    ST_PAY,
    ST_DRAIN,
    ST_DONE,
    ST_ERR
  } hdr_state_e;

  typedef enum logic [1:0] {
    ERR_NONE      = 2'd0,
    ERR_SIGNATURE = 2'd1,
    ERR_FIELD_LEN = 2'd2,
    ERR_END_KEY   = 2'd3
  } hdr_err_e;

  // Expected signature byte for position i of the preamble.
  function automatic logic [7:0] sig_byte(input int unsigned i);
    logic [7:0] b;
    if (i == 0) b = 8'h00;
    else if (i == 1) b = 8'h09;
    else if (i <= 9) b = (i % 2 == 0) ? 8'h0F : 8'hF0;
    else if (i == 12) b = 8'h01;
    else b = 8'h00;
    return b;
  endfunction

endpackage

// File: rtl/cfg_hdr_beacc.sv
// Big-endian byte accumulator: full is the value formed by the bytes
// shifted in so far with the present input byte appended as the LSB.
module cfg_hdr_beacc #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift,
  input  logic [7:0]   din,
  output logic [W-1:0] full
);
  logic [W-9:0] acc;

  assign full = {acc, din};

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else if (shift) acc <= full[W-9:0];
  end
endmodule

// File: rtl/cfg_hdr_seq.sv
module cfg_hdr_seq
  import cfg_hdr_pkg::*;
#(
  parameter int NUM_FIELDS = 4,
  parameter int FLEN_BYTES = 2,
  parameter int MAX_FIELD  = 256,
  parameter int PLEN_BYTES = 4,
  parameter logic [7:0] END_KEY = 8'h65
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       take,
  input  logic [7:0] din,
  input  logic       out_fire_last,
  output logic       run,
  output logic       pay_load,
  output logic       pay_last,
  output logic       done,
  output logic       err,
  output logic [1:0] err_code
);
  localparam int FLEN_W = 8 * FLEN_BYTES;
  localparam int PLEN_W = 8 * PLEN_BYTES;
  localparam int IDX_MAX = (SIG_LEN > FLEN_BYTES) ?
                           ((SIG_LEN > PLEN_BYTES) ? SIG_LEN : PLEN_BYTES) :
                           ((FLEN_BYTES > PLEN_BYTES) ? FLEN_BYTES : PLEN_BYTES);
  localparam int IDX_W = $clog2(IDX_MAX + 1);
  localparam int FLD_W = $clog2(NUM_FIELDS + 1);

  hdr_state_e        state, state_n;
  hdr_err_e          code, code_n;
  logic [IDX_W-1:0]  idx, idx_n;
  logic [FLD_W-1:0]  fld, fld_n;
  logic [FLEN_W-1:0] body, body_n;
  logic [PLEN_W-1:0] pay_left, pay_left_n;
  logic [FLEN_W-1:0] fl_full;
  logic [PLEN_W-1:0] pl_full;
  logic              last_field;
  logic              fl_too_long;

  cfg_hdr_beacc #(.W(FLEN_W)) u_flen (
    .clk  (clk),
    .rst  (rst),
    .shift(take && state == ST_FLEN),
    .din  (din),
    .full (fl_full)
  );

  cfg_hdr_beacc #(.W(PLEN_W)) u_plen (
    .clk  (clk),
    .rst  (rst),
    .shift(take && state == ST_PLEN),
    .din  (din),
    .full (pl_full)
  );

  assign last_field  = (fld == FLD_W'(NUM_FIELDS - 1));
  assign fl_too_long = ({1'b0, fl_full} >= (FLEN_W + 1)'(MAX_FIELD));

  always_comb begin
    state_n    = state;
    code_n     = code;
    idx_n      = idx;
    fld_n      = fld;
    body_n     = body;
    pay_left_n = pay_left;
    case (state)
      ST_SIG: if (take) begin
        if (din != sig_byte(32'(idx))) begin
          state_n = ST_ERR;
          code_n  = ERR_SIGNATURE;
        end else if (idx == IDX_W'(SIG_LEN - 1)) begin
          idx_n   = '0;
          state_n = ST_FKEY;
        end else begin
          idx_n = idx + 1'b1;
        end
      end
      ST_FKEY: if (take) begin
        idx_n   = '0;
        state_n = ST_FLEN;
      end
      ST_FLEN: if (take) begin
        if (idx == IDX_W'(FLEN_BYTES - 1)) begin
          idx_n = '0;
          if (fl_too_long) begin
            state_n = ST_ERR;
            code_n  = ERR_FIELD_LEN;
          end else if (fl_full == '0) begin
            if (last_field) state_n = ST_EKEY;
            else begin
              fld_n   = fld + 1'b1;
              state_n = ST_FKEY;
            end
          end else begin
            body_n  = fl_full;
            state_n = ST_FBODY;
          end
        end else begin
          idx_n = idx + 1'b1;
        end
      end
      ST_FBODY: if (take) begin
        body_n = body - 1'b1;
        if (body == FLEN_W'(1)) begin
          if (last_field) state_n = ST_EKEY;
          else begin
            fld_n   = fld + 1'b1;
            state_n = ST_FKEY;
          end
        end
      end
      ST_EKEY: if (take) begin
        if (din == END_KEY) begin
          idx_n   = '0;
          state_n = ST_PLEN;
        end else begin
          state_n = ST_ERR;
          code_n  = ERR_END_KEY;
        end
      end
      ST_PLEN: if (take) begin
        if (idx == IDX_W'(PLEN_BYTES - 1)) begin
          idx_n = '0;
          if (pl_full == '0) state_n = ST_DONE;
          else begin
            pay_left_n = pl_full;
            state_n    = ST_PAY;
          end
        end else begin
          idx_n = idx + 1'b1;
        end
      end
      ST_PAY: if (take) begin
        pay_left_n = pay_left - 1'b1;
        if (pay_left == PLEN_W'(1)) state_n = ST_DRAIN;
      end
      ST_DRAIN: if (out_fire_last) state_n = ST_DONE;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_SIG;
      code     <= ERR_NONE;
      idx      <= '0;
      fld      <= '0;
      body     <= '0;
      pay_left <= '0;
    end else begin
      state    <= state_n;
      code     <= code_n;
      idx      <= idx_n;
      fld      <= fld_n;
      body     <= body_n;
      pay_left <= pay_left_n;
    end
  end

  assign run      = !(state inside {ST_DRAIN, ST_DONE, ST_ERR});
  assign pay_load = take && (state == ST_PAY);
  assign pay_last = (pay_left == PLEN_W'(1));
  assign done     = (state == ST_DONE);
  assign err      = (state == ST_ERR);
  assign err_code = code;
endmodule

// File: rtl/cfg_hdr_outreg.sv
// Single output holding register for payload bytes.
module cfg_hdr_outreg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          lin,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_last
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= din;
      out_last  <= lin;
    end else if (out_ready) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end
  end
endmodule

// File: rtl/cfg_hdr_strip.sv
module cfg_hdr_strip #(
  parameter int NUM_FIELDS = 4,
  parameter int FLEN_BYTES = 2,
  parameter int MAX_FIELD  = 256,
  parameter int PLEN_BYTES = 4,
  parameter logic [7:0] END_KEY = 8'h65
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  output logic       in_ready,
  output logic [7:0] out_data,
  output logic       out_valid,
  output logic       out_last,
  input  logic       out_ready,
  output logic       done,
  output logic       err,
  output logic [1:0] err_code
);
  logic run, take, pay_load, pay_last, stall, fire_last;

  assign stall     = out_valid && !out_ready;
  assign in_ready  = run && !stall;
  assign take      = in_valid && in_ready;
  assign fire_last = out_valid && out_ready && out_last;

  cfg_hdr_seq #(
    .NUM_FIELDS(NUM_FIELDS),
    .FLEN_BYTES(FLEN_BYTES),
    .MAX_FIELD (MAX_FIELD),
    .PLEN_BYTES(PLEN_BYTES),
    .END_KEY   (END_KEY)
  ) u_seq (
    .clk          (clk),
    .rst          (rst),
    .take         (take),
    .din          (in_data),
    .out_fire_last(fire_last),
    .run          (run),
    .pay_load     (pay_load),
    .pay_last     (pay_last),
    .done         (done),
    .err          (err),
    .err_code     (err_code)
  );

  cfg_hdr_outreg #(.DW(8)) u_out (
    .clk      (clk),
    .rst      (rst),
    .load     (pay_load),
    .din      (in_data),
    .lin      (pay_last),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .out_data (out_data),
    .out_last (out_last)
  );
endmodule

// File: rtl/cfg_hdr_chk.sv
module cfg_hdr_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_ready,
  input logic [7:0] out_data,
  input logic       out_valid,
  input logic       out_last,
  input logic       out_ready,
  input logic       done,
  input logic       err,
  input logic [1:0] err_code
);
  // R8: error is sticky and its code does not change
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err |=> (err && $stable(err_code)));

  // R8: a failed parse neither accepts input nor offers output
  a_r8_quiet_on_err: assert property (@(posedge clk) disable iff (rst)
    err |-> (!in_ready && !out_valid));

  // R7: done is sticky and exclusive with err
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
    done |=> done);
  a_r7_done_not_err: assert property (@(posedge clk) disable iff (rst)
    !(done && err));

  // R10: a stalled output byte holds
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R9: a stalled output blocks input
  a_r9_stall_blocks: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R5: nothing more is accepted once the final byte has left
  a_r5_closed_after_last: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_last) |=> (!in_ready && done));
endmodule

bind cfg_hdr_strip cfg_hdr_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_ready (in_ready),
  .out_data (out_data),
  .out_valid(out_valid),
  .out_last (out_last),
  .out_ready(out_ready),
  .done     (done),
  .err      (err),
  .err_code (err_code)
);

// File: tb/sim_cfg_hdr_strip.sv
module sim_cfg_hdr_strip;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] in_data = 8'h00;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] out_data;
  logic       out_valid;
  logic       out_last;
  logic       out_ready = 1'b0;
  logic       done;
  logic       err;
  logic [1:0] err_code;

  always #5 clk = ~clk;

  cfg_hdr_strip u0 (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
    .out_last(out_last), .out_ready(out_ready), .done(done), .err(err),
    .err_code(err_code)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  logic [7:0] img[$];
  logic [7:0] exp_pay[$];
  int         stop_at;
  int         exp_code;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string code_req(input int c);
    if (c == 1) return "R1";
    if (c == 2) return "R3";
    if (c == 3) return "R4";
    return "R8";
  endfunction

  // Build an image and work out, from the rules alone, where parsing stops.
  task automatic build(input int l0, input int l1, input int l2, input int l3,
                       input logic [7:0] ekey, input int plen, input int extra,
                       input int bad_sig);
    logic [7:0] sig[13] = '{8'h00, 8'h09, 8'h0F, 8'hF0, 8'h0F, 8'hF0, 8'h0F,
                            8'hF0, 8'h0F, 8'hF0, 8'h00, 8'h00, 8'h01};
    int lens[4];
    int pos;
    lens = '{l0, l1, l2, l3};
    img.delete();
    exp_pay.delete();
    for (int i = 0; i < 13; i++)
      img.push_back((i == bad_sig) ? (sig[i] ^ 8'h40) : sig[i]);
    for (int f = 0; f < 4; f++) begin
      img.push_back(8'($urandom));
      img.push_back(8'(lens[f] >> 8));
      img.push_back(8'(lens[f]));
      for (int k = 0; k < lens[f] && k < 300; k++) img.push_back(8'($urandom));
    end
    img.push_back(ekey);
    img.push_back(8'(plen >> 24));
    img.push_back(8'(plen >> 16));
    img.push_back(8'(plen >> 8));
    img.push_back(8'(plen));
    for (int k = 0; k < plen + extra; k++) img.push_back(8'($urandom));
    // reference model of the stop point
    exp_code = 0;
    if (bad_sig >= 0) begin
      exp_code = 1; stop_at = bad_sig + 1;
    end else begin
      pos = 13;
      for (int f = 0; f < 4 && exp_code == 0; f++) begin
        pos += 3;
        if (lens[f] >= 256) begin exp_code = 2; stop_at = pos; end
        else pos += lens[f];
      end
      if (exp_code == 0) begin
        if (ekey != 8'h65) begin exp_code = 3; stop_at = pos + 1; end
        else begin
          stop_at = pos + 5 + plen;
          for (int k = 0; k < plen; k++) exp_pay.push_back(img[pos + 5 + k]);
        end
      end
    end
  endtask

  task automatic run_image(input string name, input bit bp, input bit bubbles);
    int consumed = 0;
    int oidx = 0;
    int tail = 0;
    bit prev_stall = 0;
    logic [7:0] prev_data = 8'h00;
    logic prev_last = 1'b0;
    bit exp_inr, exp_err, exp_done;
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(in_ready == 1'b1, "R11", {name, " in_ready after reset"}, in_ready, 1);
    chk(out_valid == 1'b0, "R11", {name, " out_valid after reset"}, out_valid, 0);
    chk(done == 1'b0 && err == 1'b0, "R11", {name, " done/err after reset"}, {done, err}, 0);
    chk(err_code == 2'd0, "R11", {name, " err_code after reset"}, err_code, 0);
    for (int cyc = 0; cyc < 6000 && tail < 5; cyc++) begin
      in_valid  = (consumed < img.size()) && (!bubbles || ($urandom % 3 != 0));
      in_data   = (consumed < img.size()) ? img[consumed] : 8'h00;
      out_ready = !bp || ($urandom % 2 == 0);
      #1;
      exp_inr  = (consumed < stop_at) && !(out_valid && !out_ready);
      exp_err  = (exp_code != 0) && (consumed == stop_at);
      exp_done = (exp_code == 0) && (consumed == stop_at) && (oidx == exp_pay.size());
      chk(in_ready == exp_inr, "R9", {name, " in_ready"}, in_ready, exp_inr);
      chk(err == exp_err, code_req(exp_code), {name, " err"}, err, exp_err);
      if (exp_err)
        chk(err_code == 2'(exp_code), code_req(exp_code), {name, " err_code"}, err_code, exp_code);
      chk(done == exp_done, "R7", {name, " done"}, done, exp_done);
      if (prev_stall)
        chk(out_valid && out_data == prev_data && out_last == prev_last, "R10",
            {name, " held byte"}, {out_valid, out_data, out_last}, {1'b1, prev_data, prev_last});
      if (out_valid && exp_code != 0)
        chk(0, "R8", {name, " output after error"}, out_valid, 0);
      if (out_valid && out_ready && exp_code == 0) begin
        if (oidx < exp_pay.size()) begin
          chk(out_data == exp_pay[oidx], "R5", {name, " payload byte"}, out_data, exp_pay[oidx]);
          chk(out_last == (oidx == exp_pay.size() - 1), "R6", {name, " last flag"},
              out_last, (oidx == exp_pay.size() - 1));
        end else begin
          chk(0, "R5", {name, " extra output byte"}, oidx, exp_pay.size());
        end
        oidx++;
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      prev_last  = out_last;
      if (in_valid && in_ready) consumed++;
      if (consumed == stop_at && (exp_code != 0 || oidx == exp_pay.size())) tail++;
      @(negedge clk);
    end
    chk(consumed == stop_at, (exp_code == 0) ? "R5" : "R8", {name, " bytes accepted"},
        consumed, stop_at);
    chk(oidx == exp_pay.size(), (exp_code == 0) ? "R5" : "R8", {name, " bytes forwarded"},
        oidx, exp_pay.size());
    in_valid = 1'b0;
  endtask

  initial begin
    // R2 R3: mixed record lengths including 0 and the 255 limit
    build(3, 0, 255, 1, 8'h65, 5, 3, -1);
    run_image("basic", 0, 0);
    build(7, 2, 0, 9, 8'h65, 40, 4, -1);
    run_image("backpressure", 1, 1);
    // R7: zero-length payload
    build(1, 1, 1, 1, 8'h65, 0, 2, -1);
    run_image("zero_len", 1, 1);
    build(0, 0, 0, 0, 8'h65, 1, 2, -1);
    run_image("one_byte", 1, 0);
    build(0, 0, 0, 0, 8'h65, 3, 0, -1);
    run_image("empty_records", 0, 1);
    // R1: signature faults at first and final position
    build(1, 1, 1, 1, 8'h65, 4, 0, 0);
    run_image("bad_sig_first", 0, 0);
    build(1, 1, 1, 1, 8'h65, 4, 0, 12);
    run_image("bad_sig_last", 1, 1);
    // R3: record of exactly 256 and a much longer one
    build(2, 4, 256, 1, 8'h65, 4, 0, -1);
    run_image("field_256", 0, 0);
    build(4660, 0, 0, 0, 8'h65, 4, 0, -1);
    run_image("field_big", 0, 1);
    // R4: wrong end tag
    build(2, 2, 2, 2, 8'h66, 4, 0, -1);
    run_image("bad_key", 0, 0);
    build(8, 0, 5, 3, 8'h65, 200, 1, -1);
    run_image("long_payload", 1, 1);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule